// File: doc/BRIEF.md
# Endian-Reversing Load/Store Unit

This unit sits between a CPU execute stage and a 32-bit data memory port. It carries out byte, halfword and word loads and stores, and a byte-order-reversed form of each. The execute stage hands over one access at a time. Each access carries:
- the two size bits of the opcode,
- a flag that marks the immediate form,
- the raw instruction word,
- the effective address,
- the store data,
- the destination register index.

For a reversed access the unit mirrors the sub-word address bits and swaps the data bytes in both directions. Software can therefore read and write the same memory in the opposite byte order without any extra instructions.

The bus uses big-endian lane order: address offset 0 selects bits 31:24. The memory side uses a request/acknowledge handshake. Each access ends in a one-cycle response that carries one of the following:
- the zero-extended load result and a register write enable,
- an illegal-opcode exception,
- an alignment exception.

An access that raises an exception never reaches memory.

Top module: `endian_lsu`

## Requirements
- R1: Size code 0/1/2 selects 1/2/4 bytes. Byte lane enables on `mem_be_o` are bit 3 for offset 0 through bit 0 for offset 3. Bytes enable only the lane of the final address. Halfwords enable 4'b1100 when final address bit 1 is 0 and 4'b0011 when it is 1. Words enable 4'b1111.
- R2: The reverse flag is `instr_i[9]` when `imm_form_i` is 0. When `imm_form_i` is 1 the reverse flag is 0 whatever bit 9 holds.
- R3: A reversed byte access replaces address bits 1:0 (value a) with 3−a and leaves all upper bits unchanged. The data is not swapped.
- R4: A reversed halfword access inverts address bit 1. Load results and store lanes carry the low 16 bits with their two bytes exchanged, and bits 31:16 of a load result are zero.
- R5: A reversed word access keeps the address. All four bytes are swapped, for load results and for store data alike.
- R6: A normal load returns the selected byte or halfword lane zero-extended to 32 bits. A normal store replicates the byte (or halfword) on every lane (or both halves).
- R7: A load with destination index 0 still issues the memory read, but `rf_we_o` stays 0 in its response.
- R8: With `ill_exc_en_i`=1 and size code 3, no memory request is issued. The next cycle brings a response with `exc_o`=1, `exc_cause_o`=2 and `exc_size_m1_o`=7. With `ill_exc_en_i`=0, size code 3 is carried out as a word access.
- R9: With `align_exc_en_i`=1, an access of 2 or 4 bytes whose final address is not a multiple of its size issues no memory request. The next cycle brings a response with `exc_o`=1 and `exc_cause_o`=1. It also carries `rf_idx_o` = destination index, `exc_store_o` = direction and `exc_size_m1_o` = size−1.
- R10: With `align_exc_en_i`=0, a misaligned access proceeds. Its lanes are chosen as in R1, ignoring the address bits below the access size.
- R11: `req_ready_o` is high only while no access is in flight. `mem_req_o` and its address, enables, data and direction stay stable until `mem_ack_i`. `rsp_valid_o` pulses for exactly one cycle, starting the cycle after the acknowledge.
- R12: After reset `mem_req_o`, `rsp_valid_o`, `rf_we_o` and `exc_o` are 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access offered by execute stage |
| req_ready_o | output | 1 | Unit idle, access accepted this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_code_i | input | 2 | Opcode size bits |
| imm_form_i | input | 1 | Immediate-form instruction |
| instr_i | input | 32 | Instruction word (bit 9 = reverse) |
| addr_i | input | 32 | Effective address |
| wdata_i | input | 32 | Store data |
| rd_idx_i | input | 5 | Destination register index |
| ill_exc_en_i | input | 1 | Illegal-opcode exception enable |
| align_exc_en_i | input | 1 | Unaligned exception enable |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Final (remapped) address |
| mem_be_o | output | 4 | Byte lane enables, bit 3 = offset 0 |
| mem_wdata_o | output | 32 | Lane-placed store data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | 32 | Load result |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Destination index of the response |
| exc_o | output | 1 | Exception raised |
| exc_cause_o | output | 5 | 1 = alignment, 2 = illegal opcode |
| exc_store_o | output | 1 | Faulting access was a store |
| exc_size_m1_o | output | 3 | Access size minus one |

## Verification
The hardest case to reach from the ports combines three conditions. The address must be remapped, the access must be misaligned, and the exception enables must be in a particular state. An example is a reversed halfword at an odd address, where the remap leaves bit 0 alone and the fault must still fire. Fixed-seed random stimulus draws all four size codes, both forms, random bit 9, both enables and random addresses, so these combinations recur many times. Directed cases pin every byte offset under reversal, the immediate form with bit 9 set, destination zero, and size code 3 with the illegal enable on and off. Acknowledge delays of zero to three cycles check that the request stays stable.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB = DW / 8;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_MEM = 1'b1} state_e;

  localparam logic [4:0] CAUSE_ALIGN   = 5'd1;
  localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
endpackage

// File: rtl/lsu_remap.sv
module lsu_remap #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  lsu_pkg::size_e         size_i,
  input  logic                   rev_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [lsu_pkg::NB-1:0] be_o,
  output logic                   misalign_o
);
  import lsu_pkg::*;

  always_comb begin
    addr_o = addr_i;
    if (rev_i) begin
      unique case (size_i)
        SZ_B:    addr_o[1:0] = 2'd3 - addr_i[1:0];
        SZ_H:    addr_o[1]   = ~addr_i[1];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_B: begin
        be_o       = 4'b1000 >> addr_o[1:0];
        misalign_o = 1'b0;
      end
      SZ_H: begin
        be_o       = addr_o[1] ? 4'b0011 : 4'b1100;
        misalign_o = addr_o[0];
      end
      default: begin
        be_o       = 4'b1111;
        misalign_o = |addr_o[1:0];
      end
    endcase
  end
endmodule

// File: rtl/lsu_wlane.sv
module lsu_wlane (
  input  logic [lsu_pkg::DW-1:0] data_i,
  input  lsu_pkg::size_e         size_i,
  input  logic                   rev_i,
  output logic [lsu_pkg::DW-1:0] data_o
);
  import lsu_pkg::*;

  logic [DW-1:0] swp;
  logic [15:0]   half;

  for (genvar g = 0; g < NB; g++) begin : g_swap
    assign swp[8*g +: 8] = data_i[DW-8-8*g +: 8];
  end

  assign half = rev_i ? {data_i[7:0], data_i[15:8]} : data_i[15:0];

  always_comb begin
    unique case (size_i)
      SZ_B:    data_o = {NB{data_i[7:0]}};
      SZ_H:    data_o = {2{half}};
      default: data_o = rev_i ? swp : data_i;
    endcase
  end
endmodule

// File: rtl/lsu_rlane.sv
module lsu_rlane (
  input  logic [lsu_pkg::DW-1:0] data_i,
  input  logic [1:0]             off_i,
  input  lsu_pkg::size_e         size_i,
  input  logic                   rev_i,
  output logic [lsu_pkg::DW-1:0] data_o
);
  import lsu_pkg::*;

  logic [7:0]    lane [NB];
  logic [DW-1:0] swp;
  logic [15:0]   half;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g]       = data_i[DW-1-8*g -: 8];
    assign swp[8*g +: 8] = data_i[DW-8-8*g +: 8];
  end

  always_comb begin
    half = off_i[1] ? data_i[15:0] : data_i[31:16];
    if (rev_i) half = {half[7:0], half[15:8]};
  end

  always_comb begin
    unique case (size_i)
      SZ_B:    data_o = {24'd0, lane[off_i]};
      SZ_H:    data_o = {16'd0, half};
      default: data_o = rev_i ? swp : data_i;
    endcase
  end
endmodule

// File: rtl/endian_lsu.sv
module endian_lsu #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned RIDX_W  = 5,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned REV_BIT = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               is_store_i,
  input  logic [1:0]         size_code_i,
  input  logic               imm_form_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [RIDX_W-1:0]  rd_idx_i,
  input  logic               ill_exc_en_i,
  input  logic               align_exc_en_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [3:0]         mem_be_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [31:0]        mem_rdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_data_o,
  output logic               rf_we_o,
  output logic [RIDX_W-1:0]  rf_idx_o,
  output logic               exc_o,
  output logic [4:0]         exc_cause_o,
  output logic               exc_store_o,
  output logic [2:0]         exc_size_m1_o
);
  import lsu_pkg::*;

  state_e             state_q;
  size_e              req_size, eff_size, pend_size_q;
  logic               rev_req, illegal, misalign, take_exc;
  logic [ADDR_W-1:0]  map_addr;
  logic [NB-1:0]      map_be;
  logic [DW-1:0]      lane_wdata, ld_data;
  logic [2:0]         size_m1;

  logic               pend_we_q, pend_rev_q;
  logic [ADDR_W-1:0]  pend_addr_q;
  logic [NB-1:0]      pend_be_q;
  logic [DW-1:0]      pend_wdata_q;
  logic [RIDX_W-1:0]  pend_rd_q;

  logic               rsp_valid_q, rf_we_q, exc_q, exc_store_q;
  logic [DW-1:0]      rsp_data_q;
  logic [4:0]         exc_cause_q;
  logic [2:0]         exc_size_m1_q;

  logic unused_instr;
  assign unused_instr = ^instr_i;

  assign req_size = size_e'(size_code_i);
  assign rev_req  = ~imm_form_i & instr_i[REV_BIT];
  assign illegal  = ill_exc_en_i & (req_size == SZ_D);
  // size code 3 without the illegal check runs as a word
  assign eff_size = (req_size == SZ_D) ? SZ_W : req_size;
  assign size_m1  = 3'((4'd1 << size_code_i) - 4'd1);

  lsu_remap #(.ADDR_W(ADDR_W)) u_remap (
    .addr_i     (addr_i),
    .size_i     (eff_size),
    .rev_i      (rev_req),
    .addr_o     (map_addr),
    .be_o       (map_be),
    .misalign_o (misalign)
  );

  lsu_wlane u_wlane (
    .data_i (wdata_i),
    .size_i (eff_size),
    .rev_i  (rev_req),
    .data_o (lane_wdata)
  );

  lsu_rlane u_rlane (
    .data_i (mem_rdata_i),
    .off_i  (pend_addr_q[1:0]),
    .size_i (pend_size_q),
    .rev_i  (pend_rev_q),
    .data_o (ld_data)
  );

  assign take_exc = illegal | (align_exc_en_i & misalign);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      pend_we_q     <= 1'b0;
      pend_rev_q    <= 1'b0;
      pend_size_q   <= SZ_B;
      pend_addr_q   <= '0;
      pend_be_q     <= '0;
      pend_wdata_q  <= '0;
      pend_rd_q     <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_data_q    <= '0;
      rf_we_q       <= 1'b0;
      exc_q         <= 1'b0;
      exc_cause_q   <= '0;
      exc_store_q   <= 1'b0;
      exc_size_m1_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rf_we_q     <= 1'b0;
      exc_q       <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          pend_we_q     <= is_store_i;
          pend_rev_q    <= rev_req;
          pend_size_q   <= eff_size;
          pend_addr_q   <= map_addr;
          pend_be_q     <= map_be;
          pend_wdata_q  <= lane_wdata;
          pend_rd_q     <= rd_idx_i;
          exc_store_q   <= is_store_i;
          exc_size_m1_q <= size_m1;
          if (take_exc) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '0;
            exc_q       <= 1'b1;
            exc_cause_q <= illegal ? CAUSE_ILLEGAL : CAUSE_ALIGN;
          end else begin
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= pend_we_q ? '0 : ld_data;
          rf_we_q     <= ~pend_we_q & (pend_rd_q != '0);
          exc_cause_q <= '0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_MEM);
  assign mem_we_o      = pend_we_q;
  assign mem_addr_o    = pend_addr_q;
  assign mem_be_o      = pend_be_q;
  assign mem_wdata_o   = pend_wdata_q;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_data_o    = rsp_data_q;
  assign rf_we_o       = rf_we_q;
  assign rf_idx_o      = pend_rd_q;
  assign exc_o         = exc_q;
  assign exc_cause_o   = exc_cause_q;
  assign exc_store_o   = exc_store_q;
  assign exc_size_m1_o = exc_size_m1_q;

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o)); // R11
  AST_RSP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> rsp_valid_o && !exc_o && req_ready_o); // R11
  AST_LANE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
      || $countones(mem_be_o) == 4)); // R1
  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> rsp_valid_o && !rf_we_o); // R9
  AST_EXC_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && ill_exc_en_i && size_code_i == 2'd3 |=> !mem_req_o && exc_o); // R8
endmodule

// File: tb/endian_lsu_bench.sv
module endian_lsu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, is_store = 1'b0, imm_form = 1'b0;
  logic [1:0]  size_code = '0;
  logic [31:0] instr = '0, addr = '0, wdata = '0, rdata = '0;
  logic [4:0]  rd_idx = '0;
  logic        ill_en = 1'b0, aln_en = 1'b0, ack = 1'b0;
  logic        req_ready, mem_req, mem_we, rsp_valid, rf_we, exc, exc_store;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_be;
  logic [4:0]  rf_idx, exc_cause;
  logic [2:0]  exc_size_m1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  endian_lsu u_endian_lsu (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .is_store_i(is_store), .size_code_i(size_code), .imm_form_i(imm_form), .instr_i(instr),
    .addr_i(addr), .wdata_i(wdata), .rd_idx_i(rd_idx), .ill_exc_en_i(ill_en),
    .align_exc_en_i(aln_en), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .exc_o(exc), .exc_cause_o(exc_cause), .exc_store_o(exc_store), .exc_size_m1_o(exc_size_m1)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int nbytes(input logic [1:0] code);
    return (code == 2'd3) ? 4 : (1 << code);
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] d);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) r = (r << 8) | ((d >> (8 * i)) & 32'hFF);
    return r;
  endfunction

  function automatic logic [31:0] ref_addr(input logic [31:0] a, input int n, input bit rev);
    logic [1:0] lo = a[1:0];
    if (rev && n == 1) lo = 2'(3 - int'(a[1:0]));
    if (rev && n == 2) lo = lo ^ 2'b10;
    return {a[31:2], lo};
  endfunction

  function automatic logic [3:0] ref_be(input logic [1:0] lo, input int n);
    if (n == 4) return 4'hF;
    if (n == 2) return (lo < 2) ? 4'hC : 4'h3;
    return 4'(1 << (3 - int'(lo)));
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [31:0] d, input int n, input bit rev);
    logic [15:0] h;
    if (n == 1) return {4{d[7:0]}};
    if (n == 2) begin
      h = rev ? 16'(bswap(d) >> 16) : d[15:0];
      return {h, h};
    end
    return rev ? bswap(d) : d;
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] m, input logic [1:0] lo, input int n, input bit rev);
    logic [31:0] h;
    if (n == 1) return (m >> (8 * (3 - int'(lo)))) & 32'hFF;
    if (n == 2) begin
      h = (m >> ((lo >= 2) ? 0 : 16)) & 32'hFFFF;
      return rev ? ((h >> 8) | ((h & 32'hFF) << 8)) : h;
    end
    return rev ? bswap(m) : m;
  endfunction

  function automatic string dtag(input int n, input bit rev);
    if (!rev) return "R6";
    if (n == 1) return "R3";
    if (n == 2) return "R4";
    return "R5";
  endfunction

  task automatic run(input bit st, input logic [1:0] code, input bit imm, input logic [31:0] ins,
                     input logic [31:0] a, input logic [31:0] wd, input logic [4:0] rd,
                     input bit ie, input bit ae, input int dly, input logic [31:0] md);
    int n = nbytes(code);
    bit rev = !imm && ins[9];
    logic [31:0] fa = ref_addr(a, n, rev);
    bit ill = ie && code == 2'd3;
    bit mis = ae && ((n == 2 && fa[0]) || (n == 4 && fa[1:0] != 2'd0));
    logic [31:0] exp_ld;
    string tg = dtag(n, rev);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; is_store = st; size_code = code; imm_form = imm; instr = ins;
    addr = a; wdata = wd; rd_idx = rd; ill_en = ie; aln_en = ae;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ill || mis) begin
      chk(mem_req == 1'b0, ill ? "R8 no request" : "R9 no request", 32'(mem_req), 32'd0);
      chk(rsp_valid && exc && !rf_we, ill ? "R8 exception" : "R9 exception",
          {rsp_valid, exc, rf_we}, 32'b110);
      chk(exc_cause == (ill ? 5'd2 : 5'd1), ill ? "R8 cause" : "R9 cause", 32'(exc_cause), ill ? 32'd2 : 32'd1);
      chk(exc_size_m1 == 3'((1 << code) - 1) && exc_store == st && rf_idx == rd,
          ill ? "R8 report" : "R9 report", {exc_size_m1, exc_store, rf_idx},
          {3'((1 << code) - 1), st, rd});
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 single pulse", 32'(rsp_valid), 32'd0);
      return;
    end
    chk(mem_req && mem_we == st, "R11 request", {mem_req, mem_we}, {1'b1, st});
    chk(mem_addr == fa, {tg, " address"}, mem_addr, fa);
    chk(mem_be == ref_be(fa[1:0], n), (!ae && fa[0]) ? "R10 lanes" : "R1 lanes", 32'(mem_be), 32'(ref_be(fa[1:0], n)));
    if (st) chk(mem_wdata == ref_wdata(wd, n, rev), {tg, " store data"}, mem_wdata, ref_wdata(wd, n, rev));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == fa && !rsp_valid, "R11 hold", mem_addr, fa);
    end
    ack = 1'b1; rdata = md;
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0;
    chk(rsp_valid && !exc && !mem_req, "R11 response", {rsp_valid, exc, mem_req}, 32'b100);
    exp_ld = st ? 32'd0 : ref_load(md, fa[1:0], n, rev);
    chk(rsp_data == exp_ld, {tg, " load data"}, rsp_data, exp_ld);
    chk(rf_we == (!st && rd != 0) && rf_idx == rd, (rd == 0) ? "R7 write enable" : "R6 write enable",
        {rf_we, rf_idx}, {(!st && rd != 0), rd});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd20250);
    repeat (3) @(negedge clk);
    chk(!mem_req && !rsp_valid && !rf_we && !exc && req_ready, "R12 reset",
        {mem_req, rsp_valid, rf_we, exc, req_ready}, 32'b00001);
    rst_n = 1'b1;
    // reversed bytes, each offset
    for (int o = 0; o < 4; o++) begin
      run(0, 2'd0, 0, 32'h200, 32'h1000 + o, '0, 5'd3, 1, 1, 0, 32'hA1B2C3D4);
      run(1, 2'd0, 0, 32'h200, 32'h1000 + o, 32'h55, 5'd3, 1, 1, 1, '0);
    end
    run(0, 2'd1, 0, 32'h200, 32'h2000, '0, 5'd4, 1, 1, 1, 32'h11223344); // R4
    run(0, 2'd1, 0, 32'h200, 32'h2002, '0, 5'd4, 1, 1, 0, 32'h11223344); // R4
    run(1, 2'd1, 0, 32'h200, 32'h2002, 32'hFFFF_ABCD, 5'd4, 1, 1, 0, '0); // R4
    run(0, 2'd2, 0, 32'h200, 32'h3000, '0, 5'd5, 1, 1, 2, 32'h01020304); // R5
    run(1, 2'd2, 0, 32'h200, 32'h3000, 32'hDEADBEEF, 5'd5, 1, 1, 0, '0); // R5
    run(0, 2'd0, 1, 32'h200, 32'h4001, '0, 5'd6, 1, 1, 0, 32'hA1B2C3D4); // R2 imm ignores bit 9
    run(0, 2'd0, 0, 32'h000, 32'h4001, '0, 5'd6, 1, 1, 0, 32'hA1B2C3D4); // R6
    run(0, 2'd2, 0, 32'h000, 32'h5000, '0, 5'd0, 1, 1, 1, 32'h12345678); // R7
    run(0, 2'd3, 0, 32'h000, 32'h6000, '0, 5'd7, 1, 1, 0, '0); // R8
    run(1, 2'd3, 0, 32'h000, 32'h6000, 32'h9, 5'd7, 0, 1, 0, '0); // R8 word fallback
    run(0, 2'd1, 0, 32'h200, 32'h7001, '0, 5'd8, 1, 1, 0, '0); // R9
    run(1, 2'd2, 0, 32'h000, 32'h7002, 32'h1, 5'd9, 1, 1, 0, '0); // R9
    run(0, 2'd2, 0, 32'h000, 32'h7003, '0, 5'd9, 1, 0, 0, 32'hCAFEF00D); // R10
    run(0, 2'd1, 0, 32'h200, 32'h7003, '0, 5'd9, 1, 0, 0, 32'hCAFEF00D); // R10
    for (int k = 0; k < 400; k++) begin
      logic [4:0] rr = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) rr = '0;
      run(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom, rr,
          1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom);
    end
    if (seed == 0) $display("seed zero");
    finish_run();
  end
endmodule